// File: doc/BRIEF.md
# Monitor Channel Command Decoder

This block sits behind the byte deframer of a serial control channel on a two-line telephony interface device. It takes one message at a time from the host as a stream of bytes with a valid strobe. A separate end-of-message strobe closes each message. The first byte chooses the target: either a set of line channels (A, B or both) for a register access, or an identification query. For a register access, the next byte gives the direction and the operation, and the byte after that gives the starting register address.

Writes are issued as one strobe per enabled channel for every data byte, and the address steps up after each byte. Reads are paced by a frame tick. On each tick the block makes one request to an external register read port and returns the data as an outgoing byte in the next cycle. An identification query is answered with two fixed bytes, then two frames of end-of-message signalling. Malformed messages raise a one-cycle abort and the decoder goes back to waiting for a target byte.

Top module: `mon_cmd_decoder`

## Requirements
- R1: While reset is held and in the cycles after it is released, `reg_wr_en`, `reg_rd_req`, `abort`, `out_valid` and `out_eom` are all 0.
- R2: In the target byte, bit 4 is A, bit 3 is B and bit 1 is C. With C=1, a data byte of a write pulses `reg_wr_en[0]` only if A=1 and `reg_wr_en[1]` only if B=1. A channel whose bit is 0 gets no strobe. The target byte never raises `abort` when C=1.
- R3: In the operation byte, bit 7 is the direction (1 = read, 0 = write) and bits 6:0 must be 000_0001. Any other value of bits 6:0 pulses `abort` in the cycle the byte is presented, and the next byte is taken as a target byte.
- R4: The register address byte produces no write strobe. Each following data byte of a write presents `reg_wdata` equal to that byte and `reg_addr` equal to the register address plus the number of earlier data bytes, modulo 256, in the same cycle as its strobe.
- R5: During a read, each `frame_tick` raises `reg_rd_req` in that same cycle, with `reg_addr` stepping by one per request. `reg_rd_sel` is 0 when A is enabled and 1 when only B is enabled. In the next cycle `out_valid` is 1 and `out_byte` holds the `reg_rd_data` value that was sampled.
- R6: A target byte with C=0 and B=0, followed by a byte 0x00, starts an identification reply. On the next two frame ticks the block sends 0x90 (A=1) or 0x80 (A=0), then 0xBE. Each byte appears with `out_valid` in the cycle after its tick.
- R7: After the two identification bytes, `out_eom` is 1 in the cycle after each of the next two frame ticks, with `out_valid` 0. Later ticks produce no output.
- R8: A target byte with C=0 and B=1, or a nonzero second byte in an identification query, pulses `abort` in that byte's cycle.
- R9: An end-of-message strobe before the register address byte (or before the second identification byte) pulses `abort`. An end-of-message strobe while waiting for a target byte does not.
- R10: An end-of-message strobe ends a write or a read, and the next byte is decoded as a target byte. Bytes presented during an identification reply produce no write strobe and no abort.
- R11: `out_valid` and `out_eom` are never 1 together, and either one is 1 only in the cycle after a `frame_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming byte is present |
| in_byte | input | 8 | Incoming message byte |
| in_eom | input | 1 | End-of-message strobe; any byte in the same cycle is discarded |
| frame_tick | input | 1 | One-cycle pulse per frame; paces replies and reads |
| reg_wr_en | output | 2 | Write strobes, bit 0 channel A, bit 1 channel B |
| reg_addr | output | 8 | Register address for the current access |
| reg_wdata | output | 8 | Write data |
| reg_rd_req | output | 1 | Read request to the register read port |
| reg_rd_sel | output | 1 | Read channel, 0 = A, 1 = B |
| reg_rd_data | input | 8 | Read data, valid in the cycle of `reg_rd_req` |
| out_valid | output | 1 | Outgoing byte is present |
| out_byte | output | 8 | Outgoing byte |
| out_eom | output | 1 | Outgoing end-of-message frame |
| abort | output | 1 | Malformed message pulse |

## Verification
The assertions check on every cycle that write strobes only appear with an incoming byte and always advance the address by one. They also check that read requests only fall on frame ticks and that the requested data comes back as the next outgoing byte. Finally, they check that outgoing bytes and end-of-message frames are paced by ticks and never overlap. The decoding itself can only be shown by the bench's scenarios: which channel bits enable which strobe, which operation codes abort, the identification byte contents for each channel, the two closing frames, and the point in a message where an early end aborts.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int POS_A    = 4;
  localparam int POS_B    = 3;
  localparam int POS_C    = 1;
  localparam int OP_W     = BYTE_W - 1;
  localparam logic [OP_W-1:0]   OP_REGACC = OP_W'(1);
  localparam logic [BYTE_W-1:0] ID_HEAD   = 8'h80;
  localparam logic [BYTE_W-1:0] ID_TAIL   = 8'hBE;
  localparam int ID_STEPS = 4;
  localparam int PH_W     = $clog2(ID_STEPS);

  typedef enum logic [2:0] {
    ST_TARGET,
    ST_OP,
    ST_REGADR,
    ST_WRITE,
    ST_READ,
    ST_IDCHK,
    ST_IDTX
  } mcd_state_e;

  typedef struct packed {
    logic ident;
    logic [NUM_CH-1:0] ch_en;
    logic illegal;
  } target_dec_t;
endpackage

// File: rtl/mcd_target_decode.sv
module mcd_target_decode
  import mcd_pkg::*;
(
  input  logic [BYTE_W-1:0] tgt_byte,
  output target_dec_t       dec
);
  localparam int CH_POS [NUM_CH] = '{POS_A, POS_B};

  always_comb begin
    dec.ident   = ~tgt_byte[POS_C];
    dec.illegal = ~tgt_byte[POS_C] & tgt_byte[POS_B];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign dec.ch_en[g] = tgt_byte[CH_POS[g]];
  end
endmodule

// File: rtl/mcd_op_check.sv
module mcd_op_check
  import mcd_pkg::*;
(
  input  logic [BYTE_W-1:0] op_byte,
  output logic              op_read,
  output logic              op_ok
);
  always_comb begin
    op_read = op_byte[BYTE_W-1];
    op_ok   = (op_byte[OP_W-1:0] == OP_REGACC);
  end
endmodule

// File: rtl/mcd_reply.sv
module mcd_reply
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              id_start,
  input  logic              id_sel_a,
  input  logic              rd_load,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              busy,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_eom
);
  logic            active_q, active_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            sel_q, sel_d;
  logic            vld_q, vld_d;
  logic            eom_q, eom_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic            byte_en;

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    sel_d    = sel_q;
    vld_d    = 1'b0;
    eom_d    = 1'b0;
    byte_d   = byte_q;
    if (id_start) begin
      active_d = 1'b1;
      phase_d  = '0;
      sel_d    = id_sel_a;
    end else if (active_q && frame_tick) begin
      phase_d = phase_q + PH_W'(1);
      case (phase_q)
        PH_W'(0): begin
          vld_d  = 1'b1;
          byte_d = ID_HEAD | (BYTE_W'(sel_q) << POS_A);
        end
        PH_W'(1): begin
          vld_d  = 1'b1;
          byte_d = ID_TAIL;
        end
        default: begin
          eom_d = 1'b1;
          if (phase_q == PH_W'(ID_STEPS - 1)) active_d = 1'b0;
        end
      endcase
    end else if (rd_load) begin
      vld_d  = 1'b1;
      byte_d = rd_byte;
    end
  end

  assign byte_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      sel_q    <= 1'b0;
      vld_q    <= 1'b0;
      eom_q    <= 1'b0;
      byte_q   <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      sel_q    <= sel_d;
      vld_q    <= vld_d;
      eom_q    <= eom_d;
      if (byte_en) byte_q <= byte_d;
    end
  end

  assign busy      = active_q;
  assign out_valid = vld_q;
  assign out_eom   = eom_q;
  assign out_byte  = byte_q;
endmodule

// File: rtl/mon_cmd_decoder.sv
module mon_cmd_decoder
  import mcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_eom,
  input  logic              frame_tick,
  output logic [NUM_CH-1:0] reg_wr_en,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd_req,
  output logic              reg_rd_sel,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_eom,
  output logic              abort
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  mcd_state_e        state_q, state_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              rw_q, rw_d;
  logic              idsel_q, idsel_d;
  logic              byte_in, wr_hit, rd_hit, id_start, reply_busy;
  target_dec_t       tdec;
  logic              op_read, op_ok;

  mcd_target_decode u_tdec (.tgt_byte(in_byte), .dec(tdec));
  mcd_op_check      u_op   (.op_byte(in_byte), .op_read(op_read), .op_ok(op_ok));

  assign byte_in = in_valid & ~in_eom;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    en_d     = en_q;
    rw_d     = rw_q;
    idsel_d  = idsel_q;
    abort    = 1'b0;
    wr_hit   = 1'b0;
    rd_hit   = 1'b0;
    id_start = 1'b0;
    case (state_q)
      ST_TARGET: begin
        if (byte_in) begin
          if (tdec.illegal) begin
            abort = 1'b1;
          end else if (tdec.ident) begin
            idsel_d = tdec.ch_en[0];
            state_d = ST_IDCHK;
          end else begin
            en_d    = tdec.ch_en;
            state_d = ST_OP;
          end
        end
      end
      ST_OP: begin
        if (in_eom) begin
          abort   = 1'b1;
          state_d = ST_TARGET;
        end else if (in_valid) begin
          if (!op_ok) begin
            abort   = 1'b1;
            state_d = ST_TARGET;
          end else begin
            rw_d    = op_read;
            state_d = ST_REGADR;
          end
        end
      end
      ST_REGADR: begin
        if (in_eom) begin
          abort   = 1'b1;
          state_d = ST_TARGET;
        end else if (in_valid) begin
          addr_d  = in_byte;
          state_d = rw_q ? ST_READ : ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (in_eom) begin
          state_d = ST_TARGET;
        end else if (in_valid) begin
          wr_hit = 1'b1;
          addr_d = addr_q + BYTE_W'(1);
        end
      end
      ST_READ: begin
        if (in_eom) begin
          state_d = ST_TARGET;
        end else if (frame_tick && (|en_q)) begin
          rd_hit = 1'b1;
          addr_d = addr_q + BYTE_W'(1);
        end
      end
      ST_IDCHK: begin
        if (in_eom) begin
          abort   = 1'b1;
          state_d = ST_TARGET;
        end else if (in_valid) begin
          if (in_byte == '0) begin
            id_start = 1'b1;
            state_d  = ST_IDTX;
          end else begin
            abort   = 1'b1;
            state_d = ST_TARGET;
          end
        end
      end
      ST_IDTX: begin
        if (!reply_busy) state_d = ST_TARGET;
      end
      default: state_d = ST_TARGET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_TARGET;
      addr_q  <= '0;
      en_q    <= '0;
      rw_q    <= 1'b0;
      idsel_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      en_q    <= en_d;
      rw_q    <= rw_d;
      idsel_q <= idsel_d;
    end
  end

  mcd_reply u_reply (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_tick (frame_tick),
    .id_start   (id_start),
    .id_sel_a   (idsel_q),
    .rd_load    (rd_hit),
    .rd_byte    (reg_rd_data),
    .busy       (reply_busy),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_eom    (out_eom)
  );

  assign reg_wr_en  = en_q & {NUM_CH{wr_hit}};
  assign reg_addr   = addr_q;
  assign reg_wdata  = in_byte;
  assign reg_rd_req = rd_hit;
  assign reg_rd_sel = ~en_q[0];
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker
  import mcd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_eom,
  input logic              frame_tick,
  input logic [NUM_CH-1:0] reg_wr_en,
  input logic [BYTE_W-1:0] reg_addr,
  input logic              reg_rd_req,
  input logic [BYTE_W-1:0] reg_rd_data,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_eom
);
  assert_wr_with_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_en) |-> (in_valid && !in_eom));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_en) |=> (reg_addr == $past(reg_addr) + 8'd1));

  assert_rd_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |-> frame_tick);

  assert_rd_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> (out_valid && out_byte == $past(reg_rd_data)));

  assert_no_wr_rd_mix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((|reg_wr_en) && reg_rd_req));

  assert_out_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_eom) |-> $past(frame_tick));

  assert_out_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_eom));
endmodule

bind mon_cmd_decoder mcd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_eom      (in_eom),
  .frame_tick  (frame_tick),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_rd_req  (reg_rd_req),
  .reg_rd_data (reg_rd_data),
  .out_valid   (out_valid),
  .out_byte    (out_byte),
  .out_eom     (out_eom)
);

// File: tb/mon_cmd_decoder_bench.sv
`timescale 1ns/1ps
module mon_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_eom = 1'b0;
  logic       frame_tick = 1'b0;
  logic [1:0] reg_wr_en;
  logic [7:0] reg_addr, reg_wdata, reg_rd_data, out_byte;
  logic       reg_rd_req, reg_rd_sel, out_valid, out_eom, abort;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign reg_rd_data = reg_rd_sel ? (reg_addr ^ 8'hC3) : (reg_addr + 8'h11);

  mon_cmd_decoder u_mon_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_eom(in_eom), .frame_tick(frame_tick), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_req(reg_rd_req),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data), .out_valid(out_valid),
    .out_byte(out_byte), .out_eom(out_eom), .abort(abort)
  );

  // snapshots
  logic [1:0] s_wr;
  logic [7:0] s_addr, s_wd;
  logic       s_ab, s_req, s_sel, o_vld, o_eom;
  logic [7:0] o_byte;

  // {target, op, regadr, data, expected strobes, expected abort on op byte}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {8'h92, 8'h01, 8'h10, 8'h5A, 2'b01, 1'b0},
    {8'h8A, 8'h01, 8'h33, 8'hA5, 2'b10, 1'b0},
    {8'h9A, 8'h01, 8'h7F, 8'h3C, 2'b11, 1'b0},
    {8'h82, 8'h01, 8'h40, 8'hFF, 2'b00, 1'b0},
    {8'h92, 8'h02, 8'h00, 8'h00, 2'b00, 1'b1},
    {8'h9A, 8'h7F, 8'h00, 8'h00, 2'b00, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic snap();
    #2;
    s_wr = reg_wr_en; s_addr = reg_addr; s_wd = reg_wdata; s_ab = abort;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_eom = 1'b0; in_byte = b;
    snap();
  endtask

  task automatic eom();
    @(negedge clk);
    in_valid = 1'b0; in_eom = 1'b1;
    snap();
  endtask

  task automatic rel();
    @(negedge clk);
    in_valid = 1'b0; in_eom = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    in_valid = 1'b0; in_eom = 1'b0; frame_tick = 1'b1;
    #2;
    s_req = reg_rd_req; s_sel = reg_rd_sel; s_addr = reg_addr;
    @(negedge clk);
    frame_tick = 1'b0;
    #2;
    o_vld = out_valid; o_byte = out_byte; o_eom = out_eom;
  endtask

  function automatic logic [7:0] rd_model(input logic sel, input logic [7:0] a);
    return sel ? (a ^ 8'hC3) : (a + 8'h11);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #2;
    check("R1 wr_en in reset", 8'(reg_wr_en), 8'h00);
    check("R1 out flags in reset", {6'd0, out_valid, out_eom}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R1 idle after reset", {4'd0, reg_rd_req, abort, out_valid, out_eom}, 8'h00);
    check("R1 no strobe after reset", 8'(reg_wr_en), 8'h00);

    // table of single-byte write messages, R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      put(v[34:27]);
      check("R2 target byte no abort", 8'(s_ab), 8'h00);
      put(v[26:19]);
      check("R3 op byte abort", 8'(s_ab), 8'(v[0]));
      if (!v[0]) begin
        put(v[18:11]);
        check("R4 regadr byte no strobe", 8'(s_wr), 8'h00);
        put(v[10:3]);
        check("R2 channel strobes", 8'(s_wr), 8'(v[2:1]));
        check("R4 first address", s_addr, v[18:11]);
        check("R4 write data", s_wd, v[10:3]);
      end
      eom();
      check("R10 R9 eom closes without abort", 8'(s_ab), 8'h00);
      rel();
    end

    // R4 multi-byte write with address wrap
    put(8'h9A); put(8'h01); put(8'hFE);
    put(8'h11);
    check("R4 wrap addr0", s_addr, 8'hFE);
    put(8'h22);
    check("R4 wrap addr1", s_addr, 8'hFF);
    put(8'h33);
    check("R4 wrap addr2", s_addr, 8'h00);
    check("R4 wrap data2", s_wd, 8'h33);
    check("R2 both strobes", 8'(s_wr), 8'h03);
    eom(); rel();

    // R5 read, channel B only
    put(8'h8A); put(8'h81); put(8'h20); rel();
    tick();
    check("R5 rd_req on tick", 8'(s_req), 8'h01);
    check("R5 rd_sel B", 8'(s_sel), 8'h01);
    check("R5 rd addr0", s_addr, 8'h20);
    check("R5 read byte valid", 8'(o_vld), 8'h01);
    check("R5 read byte0", o_byte, rd_model(1'b1, 8'h20));
    tick();
    check("R5 rd addr1", s_addr, 8'h21);
    check("R5 read byte1", o_byte, rd_model(1'b1, 8'h21));
    eom(); rel();
    // R10 next byte is a target byte again: read with both enabled
    put(8'h9A); put(8'h81); put(8'h05); rel();
    tick();
    check("R5 rd_sel A when both", 8'(s_sel), 8'h00);
    check("R5 read byte both", o_byte, rd_model(1'b0, 8'h05));
    eom(); rel();

    // R6 R7 identification, channel A, with bytes ignored during reply
    put(8'h90);
    check("R6 id target no abort", 8'(s_ab), 8'h00);
    put(8'h00);
    put(8'h9A);
    check("R10 byte during reply no strobe", 8'(s_wr), 8'h00);
    check("R10 byte during reply no abort", 8'(s_ab), 8'h00);
    rel();
    tick();
    check("R6 id byte0 valid", 8'(o_vld), 8'h01);
    check("R6 id byte0 A", o_byte, 8'h90);
    tick();
    check("R6 id byte1", o_byte, 8'hBE);
    tick();
    check("R7 eom frame1", {6'd0, o_vld, o_eom}, 8'h01);
    tick();
    check("R7 eom frame2", {6'd0, o_vld, o_eom}, 8'h01);
    tick();
    check("R7 silent after eom", {6'd0, o_vld, o_eom}, 8'h00);

    // R6 identification, channel B
    put(8'h80); put(8'h00); rel();
    tick();
    check("R6 id byte0 B", o_byte, 8'h80);
    tick();
    check("R6 id byte1 B", o_byte, 8'hBE);
    tick(); tick();
    check("R7 eom frame2 B", 8'(o_eom), 8'h01);
    rel();

    // R8 illegal identification
    put(8'h88);
    check("R8 C0 B1 aborts", 8'(s_ab), 8'h01);
    eom(); rel();
    put(8'h90); put(8'h05);
    check("R8 nonzero id byte aborts", 8'(s_ab), 8'h01);
    eom(); rel();
    tick();
    check("R8 no reply after abort", {6'd0, o_vld, o_eom}, 8'h00);

    // R9 early end of message
    put(8'h92); eom();
    check("R9 eom after target aborts", 8'(s_ab), 8'h01);
    rel();
    put(8'h92); put(8'h01); eom();
    check("R9 eom after op aborts", 8'(s_ab), 8'h01);
    rel();
    eom();
    check("R9 eom while idle no abort", 8'(s_ab), 8'h00);
    rel();
    // after abort a full write works
    put(8'h8A); put(8'h01); put(8'h44); put(8'h99);
    check("R3 recovery strobe", 8'(s_wr), 8'h02);
    eom(); rel();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule